// File: doc/BRIEF.md
# Current-Source Inverter Gate Pattern Generator

This block turns the comparison of one PWM carrier sample against three modulating samples into the six gate commands of a three-phase current-source inverter. Each phase yields one bit, set when that phase's modulating value is strictly above the carrier. The three bits together select at most one upper switch and at most one lower switch. In a current-source bridge the DC link current must never be left without a path. So whenever no upper switch or no lower switch is commanded, the block adds a freewheeling short across one leg, turning on both switches of that leg.

A three-bit leg select picks which leg takes the short. It is expected to be one-hot and to rotate every third of the fundamental period, so each leg carries the freewheeling current for an equal share of the time. A sample strobe qualifies the inputs. Results appear on registered outputs one clock after a qualified sample, and the outputs hold while the strobe is low. If the leg select is not one-hot, no short is added and a sticky error flag is set.

Top module: `csi_gate_gen`

## Requirements
- R1: A phase bit is 1 only when its modulating value is greater than the carrier value. Both are signed 12-bit two's-complement numbers. Equal values give 0.
- R2: Output bit i of `gate` drives switch i+1. The phase pattern {a,b,c} maps to switches as follows: 001 to 5 and 6, 010 to 3 and 4, 011 to 5 and 4, 100 to 1 and 2, 101 to 1 and 6, 110 to 3 and 2. Patterns 000 and 111 command no switch.
- R3: Before the short is added, at most one upper switch (1, 3, 5) and at most one lower switch (2, 4, 6) is commanded.
- R4: When no upper switch or no lower switch is commanded, both switches of the selected leg are turned on in addition to the decoded ones.
- R5: Bit 0 of `leg_sel` selects the leg made of switches 1 and 4. Bit 1 selects switches 3 and 6. Bit 2 selects switches 5 and 2.
- R6: A qualified sample whose `leg_sel` is not one-hot adds no short and sets `sel_err`. The flag stays set until reset.
- R7: `gate` updates on the clock edge that captures a sample with `sample_valid` high. While `sample_valid` is low, `gate` and `sel_err` hold.
- R8: Synchronous reset clears `gate` and `sel_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Qualifies the input samples |
| carrier | input | 12 | Signed carrier sample |
| mod_a | input | 12 | Signed modulating sample, phase a |
| mod_b | input | 12 | Signed modulating sample, phase b |
| mod_c | input | 12 | Signed modulating sample, phase c |
| leg_sel | input | 3 | One-hot choice of the leg that takes the short |
| gate | output | 6 | Registered gate commands, bit i is switch i+1 |
| sel_err | output | 1 | Sticky flag for a non-one-hot leg select |

## Verification
Every result of this block is due exactly one clock after the edge that captures a qualified sample. This applies to the gate pattern, to the injected short and to the error flag. Stimulus is driven on the falling edge and held across the next rising edge. The outputs are read at the following falling edge, which is after the single register and before any further sample. The hold checks leave the strobe low for two full cycles with new input values and then read the outputs. The reset checks read the outputs one falling edge after a reset edge.

// File: rtl/csi_gate_pkg.sv
package csi_gate_pkg;
  localparam int NLEG = 3;
  localparam int NSW  = 2 * NLEG;

  // Upper switches 1,3,5 sit on even bits; lower 2,4,6 on odd bits.
  localparam logic [NSW-1:0] UPPER_MASK = 6'b010101;
  localparam logic [NSW-1:0] LOWER_MASK = 6'b101010;

  // Two switches of leg k: upper on bit 2k, its partner three positions on.
  function automatic logic [NSW-1:0] leg_mask(input int k);
    logic [NSW-1:0] m;
    m = '0;
    m[(2 * k) % NSW]     = 1'b1;
    m[(2 * k + 3) % NSW] = 1'b1;
    return m;
  endfunction

  // Phase pattern {a,b,c} to switch commands, bit i = switch i+1.
  function automatic logic [NSW-1:0] phase_to_cmd(input logic [2:0] p);
    logic [NSW-1:0] c;
    case (p)
      3'b001:  c = 6'b110000;  // 5,6
      3'b010:  c = 6'b001100;  // 3,4
      3'b011:  c = 6'b011000;  // 5,4
      3'b100:  c = 6'b000011;  // 1,2
      3'b101:  c = 6'b100001;  // 1,6
      3'b110:  c = 6'b000110;  // 3,2
      default: c = '0;         // 000, 111
    endcase
    return c;
  endfunction

  function automatic logic gt_signed(input logic signed [11:0] m,
                                     input logic signed [11:0] c);
    return m > c;
  endfunction
endpackage

// File: rtl/csi_phase_cmp.sv
module csi_phase_cmp #(
  parameter int W = 12,
  parameter int N = 3
) (
  input  logic signed [W-1:0] carrier,
  input  logic [N*W-1:0]      mods,
  output logic [N-1:0]        phase
);
  // phase[N-1] is phase a, phase[0] is phase c.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic signed [W-1:0] m;
    assign m = mods[i*W +: W];
    assign phase[i] = m > carrier;
  end
endmodule

// File: rtl/csi_switch_decode.sv
module csi_switch_decode
  import csi_gate_pkg::*;
(
  input  logic [2:0]     phase,
  output logic [NSW-1:0] cmd,
  output logic           short_req
);
  logic no_upper, no_lower;

  always_comb begin
    cmd       = phase_to_cmd(phase);
    no_upper  = ~|(cmd & UPPER_MASK);
    no_lower  = ~|(cmd & LOWER_MASK);
    short_req = no_upper | no_lower;
  end

  always_comb begin
    a_r3_one_upper: assert ($countones(cmd & UPPER_MASK) <= 1)
      else $error("R3: more than one upper switch");
    a_r3_one_lower: assert ($countones(cmd & LOWER_MASK) <= 1)
      else $error("R3: more than one lower switch");
  end
endmodule

// File: rtl/csi_short_router.sv
module csi_short_router
  import csi_gate_pkg::*;
(
  input  logic [NSW-1:0]  cmd,
  input  logic            short_req,
  input  logic [NLEG-1:0] leg_sel,
  output logic [NSW-1:0]  gate_next,
  output logic [NSW-1:0]  short_mask,
  output logic            sel_bad
);
  logic            sel_ok;
  logic [NSW-1:0]  inj [NLEG];

  assign sel_ok  = $onehot(leg_sel);
  assign sel_bad = ~sel_ok;

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    localparam logic [NSW-1:0] PAIR = leg_mask(k);
    assign inj[k] = (short_req && sel_ok && leg_sel[k]) ? PAIR : '0;
  end

  always_comb begin
    short_mask = '0;
    for (int k = 0; k < NLEG; k++) short_mask = short_mask | inj[k];
    gate_next = cmd | short_mask;
  end

  always_comb begin
    a_r6_no_short_bad_sel: assert (!(sel_bad && |short_mask))
      else $error("R6: short added with bad leg select");
    a_r4_short_one_leg: assert ($countones(short_mask) == 0 || $countones(short_mask) == 2)
      else $error("R4: short not on exactly one leg");
  end
endmodule

// File: rtl/csi_gate_gen.sv
module csi_gate_gen
  import csi_gate_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_valid,
  input  logic signed [W-1:0] carrier,
  input  logic signed [W-1:0] mod_a,
  input  logic signed [W-1:0] mod_b,
  input  logic signed [W-1:0] mod_c,
  input  logic [2:0]          leg_sel,
  output logic [5:0]          gate,
  output logic                sel_err
);
  localparam int NPH = 3;

  logic [NPH-1:0] phase;
  logic [NSW-1:0] cmd, gate_next, short_mask;
  logic           short_req, sel_bad;

  csi_phase_cmp #(.W(W), .N(NPH)) u_cmp (
    .carrier (carrier),
    .mods    ({mod_a, mod_b, mod_c}),
    .phase   (phase)
  );

  csi_switch_decode u_dec (
    .phase     (phase),
    .cmd       (cmd),
    .short_req (short_req)
  );

  csi_short_router u_route (
    .cmd        (cmd),
    .short_req  (short_req),
    .leg_sel    (leg_sel),
    .gate_next  (gate_next),
    .short_mask (short_mask),
    .sel_bad    (sel_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate    <= '0;
      sel_err <= 1'b0;
    end else if (sample_valid) begin
      gate <= gate_next;
      if (sel_bad) sel_err <= 1'b1;
    end
  end

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(gate) && $stable(sel_err)))
    else $error("R7: outputs moved without a sample");
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (gate == '0 && !sel_err))
    else $error("R8: reset did not clear outputs");
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err)
    else $error("R6: error flag dropped");
  a_r4_short_lands: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && short_req && $onehot(leg_sel)) |=> ($countones(gate) == 2))
    else $error("R4: freewheel short missing");
endmodule

// File: tb/csi_gate_gen_test.sv
module csi_gate_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, sample_valid = 0;
  logic signed [11:0] carrier = 0, mod_a = 0, mod_b = 0, mod_c = 0;
  logic [2:0] leg_sel = 3'b001;
  logic [5:0] gate;
  logic sel_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csi_gate_gen uut (.*);

  // Independent model: switch numbers per pattern, then the leg short.
  function automatic logic [5:0] sw(input int s);
    return 6'b1 << (s - 1);
  endfunction

  function automatic logic [5:0] model(input logic [2:0] p, input logic [2:0] sel);
    logic [5:0] g;
    unique case (p)
      3'b001: g = sw(5) | sw(6);
      3'b010: g = sw(3) | sw(4);
      3'b011: g = sw(5) | sw(4);
      3'b100: g = sw(1) | sw(2);
      3'b101: g = sw(1) | sw(6);
      3'b110: g = sw(3) | sw(2);
      default: g = 6'b0;
    endcase
    if (g == 6'b0) begin
      if (sel == 3'b001) g = sw(1) | sw(4);
      else if (sel == 3'b010) g = sw(3) | sw(6);
      else if (sel == 3'b100) g = sw(5) | sw(2);
    end
    return g;
  endfunction

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic sample(input logic signed [11:0] c, input logic signed [11:0] a,
                        input logic signed [11:0] b, input logic signed [11:0] cc,
                        input logic [2:0] sel);
    @(negedge clk);
    carrier = c; mod_a = a; mod_b = b; mod_c = cc; leg_sel = sel; sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; sample_valid = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 reset", {sel_err, gate}, 7'b0);
  endtask

  task automatic t_decode_all();
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic [2:0] pb = p[2:0];
        logic [2:0] sel = 3'b1 << s;
        sample(12'sd0, pb[2] ? 12'sd100 : -12'sd100, pb[1] ? 12'sd100 : -12'sd100,
               pb[0] ? 12'sd100 : -12'sd100, sel);
        chk((p == 0 || p == 7) ? "R4 R5 short leg" : "R2 R3 decode",
            {sel_err, gate}, {1'b0, model(pb, sel)});
      end
    end
  endtask

  task automatic t_compare();
    // equal values are not greater: pattern 000 -> short on leg 1,4
    sample(12'sd50, 12'sd50, 12'sd50, 12'sd50, 3'b001);
    chk("R1 equal gives 0", {1'b0, gate}, {1'b0, model(3'b000, 3'b001)});
    // signed: -1 > -2048, -2048 not > -1
    sample(-12'sd1, 12'sd0, -12'sd2048, -12'sd1, 3'b010);
    chk("R1 signed compare", {1'b0, gate}, {1'b0, model(3'b100, 3'b010)});
    sample(-12'sd2048, -12'sd1, 12'sd2047, -12'sd2048, 3'b100);
    chk("R1 signed extremes", {1'b0, gate}, {1'b0, model(3'b110, 3'b100)});
  endtask

  task automatic t_hold();
    sample(12'sd0, 12'sd10, -12'sd10, 12'sd10, 3'b001);
    @(negedge clk);
    carrier = 12'sd0; mod_a = -12'sd5; mod_b = 12'sd5; mod_c = -12'sd5; leg_sel = 3'b111;
    @(negedge clk); @(negedge clk);
    chk("R7 hold while idle", {sel_err, gate}, {1'b0, model(3'b101, 3'b001)});
  endtask

  task automatic t_bad_sel();
    sample(12'sd0, -12'sd3, -12'sd3, -12'sd3, 3'b011);
    chk("R6 no short on bad select", {sel_err, gate}, 7'b1000000);
    sample(12'sd0, -12'sd3, -12'sd3, -12'sd3, 3'b000);
    chk("R6 no short on empty select", {sel_err, gate}, 7'b1000000);
    sample(12'sd0, 12'sd3, -12'sd3, -12'sd3, 3'b010);
    chk("R6 flag sticky", {sel_err, gate}, {1'b1, model(3'b100, 3'b010)});
    do_reset();
    chk("R8 reset clears flag", {sel_err, gate}, 7'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_decode_all();
    t_compare();
    t_hold();
    t_bad_sel();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule